// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt sources of a 16550-style serial port into one interrupt request line and a 3-bit identification code for the host to read. It holds the four-bit source enable register. It keeps the sticky sources pending: a line-status error, the transmit-empty indication and four modem delta flags. It takes the receive trigger and character-timeout conditions as levels. It applies the read and write side effects that retire each sticky source. The shifters, FIFOs, baud generator and bus decode are outside the block. They reach it as single-cycle strobes and levels.

A small state machine holds the source being reported. On every clock edge it moves to the highest-priority source that is both pending and enabled. The states are IDLE (nothing to report), LS (line status), RXD (receive data at trigger level), RTO (character timeout), TXE (transmit holding empty) and MS (modem status). Each state can move to any other state on the next edge. It moves to IDLE when no enabled source is pending.

The interrupt line and the identification code are decoded from the state register alone, so they are glitch-free. A sticky source that is set by a strobe becomes visible one edge after the pending bit captures the strobe. A level condition or a change to the enable register becomes visible on the next edge.

Top module: `uiid_top`

## Requirements
- R1: `int_id` reads 3 for line status, 2 for receive data, 6 for character timeout, 1 for transmit empty and 0 for modem status. When nothing is reported, `int_none`=1 and `int_id`=0. The codes 4, 5 and 7 are never driven.
- R2: The enable register bits are: bit 0 enables receive data and character timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status. It loads from `ier_wdata` on an edge where `ier_we`=1 and reads back on `ier_q`. A cleared bit masks its source.
- R3: Writing 0 to the enable register masks every source. `irq` is low from the edge after the write.
- R4: When more than one enabled source is pending, the reported source is chosen in this order: line status, then character timeout, then receive data, then transmit empty, then modem status.
- R5: `ls_evt` sets the line-status pending bit. The bit stays set until an `lsr_rd` strobe. If both strobes come in the same cycle, the bit is set.
- R6: Each `msr_delta` bit sets its own `msr_flags` bit. The flag stays set, and keeps the modem interrupt asserted while bit 3 is enabled, until an `msr_rd` strobe. A new delta in the same cycle as the read wins.
- R7: `tx_load_evt` sets transmit-empty pending, unless `thr_wr` is high in the same cycle.
- R8: Transmit-empty pending clears on `thr_wr`. It also clears on `iir_rd` when TXE is the reported source. An `iir_rd` while another source is reported leaves it pending.
- R9: `irq` and `int_id` are registered. A strobe-set source shows on the second edge after the strobe is driven. A level source or an enable change shows on the first edge.
- R10: After reset, `irq`=0, `int_none`=1, `int_id`=0, `ier_q`=0 and `msr_flags`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| ls_evt | input | 1 | Line-status error event strobe |
| lsr_rd | input | 1 | Line-status register read strobe |
| rx_trig | input | 1 | Receive FIFO at trigger level (level) |
| rx_tmo | input | 1 | Character timeout condition (level) |
| tx_load_evt | input | 1 | Holding data moved to shifter, holding now empty |
| thr_wr | input | 1 | Holding register write strobe |
| msr_delta | input | 4 | Modem delta event strobes |
| msr_rd | input | 1 | Modem status read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| irq | output | 1 | Interrupt request |
| int_id | output | 3 | Identification code |
| int_none | output | 1 | No source reported |
| ier_q | output | 4 | Enable register contents |
| msr_flags | output | 4 | Sticky modem delta flags |

## Verification
Some properties are checked on every cycle. The illegal codes never appear. A zero enable register leaves the line low on the next edge. An enabled line-status source always wins. A modem read with no new delta empties the flags, and a holding write retires transmit-empty. Other behaviour only shows in the bench scenarios. These are the full priority ordering across every combination of enables and sources, the conditional clear of transmit-empty by an identification read, the set-wins collisions, the two-edge latency of strobe-set sources, and the persistence of unread modem flags.

// File: rtl/uiid_pkg.sv
package uiid_pkg;

    localparam int EN_W   = 4;
    localparam int ID_W   = 3;

    localparam int EN_RX  = 0;
    localparam int EN_TX  = 1;
    localparam int EN_LS  = 2;
    localparam int EN_MS  = 3;

    localparam logic [ID_W-1:0] ID_MS  = 3'd0;
    localparam logic [ID_W-1:0] ID_TXE = 3'd1;
    localparam logic [ID_W-1:0] ID_RXD = 3'd2;
    localparam logic [ID_W-1:0] ID_LS  = 3'd3;
    localparam logic [ID_W-1:0] ID_RTO = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LS,
        ST_RXD,
        ST_RTO,
        ST_TXE,
        ST_MS
    } uiid_state_e;

endpackage

// File: rtl/uiid_enable_reg.sv
module uiid_enable_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/uiid_src_latch.sv
module uiid_src_latch #(
    parameter int MS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ls_evt,
    input  logic            lsr_rd,
    input  logic            tx_load_evt,
    input  logic            thr_wr,
    input  logic            txe_ack,
    input  logic [MS_W-1:0] msr_delta,
    input  logic            msr_rd,
    output logic            ls_pend,
    output logic            txe_pend,
    output logic [MS_W-1:0] ms_flags
);

    // Line status: set has precedence over the read clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_pend <= 1'b0;
        end else if (ls_evt) begin
            ls_pend <= 1'b1;
        end else if (lsr_rd) begin
            ls_pend <= 1'b0;
        end
    end

    // Transmit empty: a holding write beats both the load event and the ack.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txe_pend <= 1'b0;
        end else if (thr_wr) begin
            txe_pend <= 1'b0;
        end else if (tx_load_evt) begin
            txe_pend <= 1'b1;
        end else if (txe_ack) begin
            txe_pend <= 1'b0;
        end
    end

    // Modem deltas: one sticky flag per line.
    for (genvar i = 0; i < MS_W; i++) begin : g_ms
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ms_flags[i] <= 1'b0;
            end else if (msr_delta[i]) begin
                ms_flags[i] <= 1'b1;
            end else if (msr_rd) begin
                ms_flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uiid_prio.sv
module uiid_prio
    import uiid_pkg::*;
(
    input  logic [EN_W-1:0] ier,
    input  logic            ls_pend,
    input  logic            rx_tmo,
    input  logic            rx_trig,
    input  logic            txe_pend,
    input  logic            ms_any,
    output uiid_state_e     next_state
);

    always_comb begin
        if (ls_pend && ier[EN_LS]) begin
            next_state = ST_LS;
        end else if (rx_tmo && ier[EN_RX]) begin
            next_state = ST_RTO;
        end else if (rx_trig && ier[EN_RX]) begin
            next_state = ST_RXD;
        end else if (txe_pend && ier[EN_TX]) begin
            next_state = ST_TXE;
        end else if (ms_any && ier[EN_MS]) begin
            next_state = ST_MS;
        end else begin
            next_state = ST_IDLE;
        end
    end

endmodule

// File: rtl/uiid_top.sv
module uiid_top
    import uiid_pkg::*;
#(
    parameter int MS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ier_we,
    input  logic [EN_W-1:0] ier_wdata,
    input  logic            ls_evt,
    input  logic            lsr_rd,
    input  logic            rx_trig,
    input  logic            rx_tmo,
    input  logic            tx_load_evt,
    input  logic            thr_wr,
    input  logic [MS_W-1:0] msr_delta,
    input  logic            msr_rd,
    input  logic            iir_rd,
    output logic            irq,
    output logic [ID_W-1:0] int_id,
    output logic            int_none,
    output logic [EN_W-1:0] ier_q,
    output logic [MS_W-1:0] msr_flags
);

    uiid_state_e state_q;
    uiid_state_e state_d;
    logic        ls_pend;
    logic        txe_pend;
    logic        txe_ack;

    assign txe_ack = iir_rd && (state_q == ST_TXE);

    uiid_enable_reg #(.W(EN_W)) u_ier (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ier_we),
        .wdata (ier_wdata),
        .q     (ier_q)
    );

    uiid_src_latch #(.MS_W(MS_W)) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .ls_evt      (ls_evt),
        .lsr_rd      (lsr_rd),
        .tx_load_evt (tx_load_evt),
        .thr_wr      (thr_wr),
        .txe_ack     (txe_ack),
        .msr_delta   (msr_delta),
        .msr_rd      (msr_rd),
        .ls_pend     (ls_pend),
        .txe_pend    (txe_pend),
        .ms_flags    (msr_flags)
    );

    uiid_prio u_prio (
        .ier        (ier_q),
        .ls_pend    (ls_pend),
        .rx_tmo     (rx_tmo),
        .rx_trig    (rx_trig),
        .txe_pend   (txe_pend),
        .ms_any     (|msr_flags),
        .next_state (state_d)
    );

    // State register: the reported source.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from the state register only.
    always_comb begin
        irq      = 1'b1;
        int_none = 1'b0;
        int_id   = ID_MS;
        unique case (state_q)
            ST_IDLE: begin
                irq      = 1'b0;
                int_none = 1'b1;
                int_id   = ID_MS;
            end
            ST_LS:   int_id = ID_LS;
            ST_RXD:  int_id = ID_RXD;
            ST_RTO:  int_id = ID_RTO;
            ST_TXE:  int_id = ID_TXE;
            ST_MS:   int_id = ID_MS;
            default: begin
                irq      = 1'b0;
                int_none = 1'b1;
                int_id   = ID_MS;
            end
        endcase
    end

endmodule

// File: rtl/uiid_checker.sv
module uiid_checker #(
    parameter int MS_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      ier_q,
    input logic            irq,
    input logic [2:0]      int_id,
    input logic            msr_rd,
    input logic [MS_W-1:0] msr_delta,
    input logic [MS_W-1:0] msr_flags,
    input logic            thr_wr,
    input logic            txe_pend,
    input logic            ls_pend
);

    AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id != 3'd4) && (int_id != 3'd5) && (int_id != 3'd7)); // R1

    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == 4'd0) |=> !irq); // R3

    AST_LS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && ier_q[2]) |=> (irq && int_id == 3'd3)); // R4

    AST_MS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && msr_delta == '0) |=> (msr_flags == '0)); // R6

    AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !txe_pend); // R8

endmodule

bind uiid_top uiid_checker #(.MS_W(MS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_q     (ier_q),
    .irq       (irq),
    .int_id    (int_id),
    .msr_rd    (msr_rd),
    .msr_delta (msr_delta),
    .msr_flags (msr_flags),
    .thr_wr    (thr_wr),
    .txe_pend  (txe_pend),
    .ls_pend   (ls_pend)
);

// File: tb/sim_uiid_top.sv
`timescale 1ns/1ps
module sim_uiid_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_we = 1'b0;
    logic [3:0] ier_wdata = '0;
    logic       ls_evt = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       rx_trig = 1'b0;
    logic       rx_tmo = 1'b0;
    logic       tx_load_evt = 1'b0;
    logic       thr_wr = 1'b0;
    logic [3:0] msr_delta = '0;
    logic       msr_rd = 1'b0;
    logic       iir_rd = 1'b0;
    logic       irq;
    logic [2:0] int_id;
    logic       int_none;
    logic [3:0] ier_q;
    logic [3:0] msr_flags;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uiid_top u0 (
        .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
        .ls_evt(ls_evt), .lsr_rd(lsr_rd), .rx_trig(rx_trig), .rx_tmo(rx_tmo),
        .tx_load_evt(tx_load_evt), .thr_wr(thr_wr), .msr_delta(msr_delta),
        .msr_rd(msr_rd), .iir_rd(iir_rd), .irq(irq), .int_id(int_id),
        .int_none(int_none), .ier_q(ier_q), .msr_flags(msr_flags)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {irq, int_none, int_id} expected from the priority rules
    function automatic logic [4:0] expect_out(input logic [3:0] en, input logic [4:0] s);
        // s: [0] ls, [1] rx_trig, [2] rx_tmo, [3] txe, [4] modem
        if (s[0] && en[2]) return {2'b10, 3'd3};
        if (s[2] && en[0]) return {2'b10, 3'd6};
        if (s[1] && en[0]) return {2'b10, 3'd2};
        if (s[3] && en[1]) return {2'b10, 3'd1};
        if (s[4] && en[3]) return {2'b10, 3'd0};
        return {2'b01, 3'd0};
    endfunction

    task automatic clear_all();
        lsr_rd = 1'b1; msr_rd = 1'b1; thr_wr = 1'b1;
        rx_trig = 1'b0; rx_tmo = 1'b0;
        tick();
        lsr_rd = 1'b0; msr_rd = 1'b0; thr_wr = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        // R10 reset state
        check("R10 irq", irq, 0);
        check("R10 none", int_none, 1);
        check("R10 id", int_id, 0);
        check("R10 ier", ier_q, 0);
        check("R10 msr", msr_flags, 0);
        rst_n = 1'b1;
        tick();

        // R1 R2 R4 R9: sweep of every enable value and source set
        for (int en = 0; en < 16; en++) begin
            for (int s = 0; s < 32; s++) begin
                clear_all();
                ier_we = 1'b1; ier_wdata = en[3:0];
                ls_evt = s[0]; rx_trig = s[1]; rx_tmo = s[2];
                tx_load_evt = s[3]; msr_delta = s[4] ? 4'b0100 : 4'b0000;
                tick();
                ier_we = 1'b0; ls_evt = 1'b0; tx_load_evt = 1'b0; msr_delta = '0;
                tick();
                check("R4 sweep", {irq, int_none, int_id}, expect_out(en[3:0], s[4:0]));
                check("R2 readback", ier_q, en);
            end
        end

        // R9 latency of a strobe-set source
        clear_all();
        ier_we = 1'b1; ier_wdata = 4'b1111; tick(); ier_we = 1'b0;
        ls_evt = 1'b1; tick(); ls_evt = 1'b0;
        check("R9 not yet", irq, 0);
        tick();
        check("R9 after two edges", int_id, 3);
        check("R9 irq", irq, 1);

        // R3 zero write masks all
        ier_we = 1'b1; ier_wdata = 4'b0000; tick(); ier_we = 1'b0;
        check("R3 ier zero", ier_q, 0);
        tick();
        check("R3 irq low", irq, 0);

        // R5 collision: set wins, then read clears
        ier_we = 1'b1; ier_wdata = 4'b0100; tick(); ier_we = 1'b0;
        ls_evt = 1'b1; lsr_rd = 1'b1; tick(); ls_evt = 1'b0; lsr_rd = 1'b0;
        tick();
        check("R5 set wins", int_id, 3);
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0; tick();
        check("R5 read clears", irq, 0);

        // R6 modem flags persist until read
        clear_all();
        ier_we = 1'b1; ier_wdata = 4'b1000; tick(); ier_we = 1'b0;
        msr_delta = 4'b1001; tick(); msr_delta = '0;
        repeat (5) tick();
        check("R6 flags kept", msr_flags, 4'b1001);
        check("R6 irq kept", {irq, int_id}, {1'b1, 3'd0});
        msr_rd = 1'b1; msr_delta = 4'b0010; tick(); msr_rd = 1'b0; msr_delta = '0;
        check("R6 new delta wins", msr_flags, 4'b0010);
        msr_rd = 1'b1; tick(); msr_rd = 1'b0; tick();
        check("R6 read clears", {irq, msr_flags}, 5'b0);

        // R7 holding write in the same cycle blocks the set
        clear_all();
        ier_we = 1'b1; ier_wdata = 4'b0010; tick(); ier_we = 1'b0;
        tx_load_evt = 1'b1; thr_wr = 1'b1; tick(); tx_load_evt = 1'b0; thr_wr = 1'b0;
        tick();
        check("R7 write blocks", irq, 0);

        // R8 id read clears transmit empty only when it is reported
        tx_load_evt = 1'b1; tick(); tx_load_evt = 1'b0; tick();
        check("R8 reported", int_id, 1);
        iir_rd = 1'b1; tick(); iir_rd = 1'b0; tick();
        check("R8 ack clears", irq, 0);
        ier_we = 1'b1; ier_wdata = 4'b0110; tick(); ier_we = 1'b0;
        tx_load_evt = 1'b1; ls_evt = 1'b1; tick(); tx_load_evt = 1'b0; ls_evt = 1'b0;
        tick();
        check("R8 ls shown", int_id, 3);
        iir_rd = 1'b1; tick(); iir_rd = 1'b0;
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0; tick();
        check("R8 txe kept", {irq, int_id}, {1'b1, 3'd1});
        thr_wr = 1'b1; tick(); thr_wr = 1'b0; tick();
        check("R8 write clears", irq, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule